// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number, an address-space identifier, a physical frame number, a dirty flag, a global flag and a valid flag. A lookup compares the requested page number and the current address-space identifier against every slot at once. One cycle later the block returns the frame number and dirty flag on a hit, or a miss indication. A slot marked global matches under any identifier. Shared translations can therefore stay resident across context switches, and no full flush is needed.

After a miss, the handler walks the page table outside this block and installs the result through the fill port. A fill that names a page already present for that identifier overwrites the existing slot. Otherwise the fill takes the lowest-numbered free slot. When every slot is in use, a round-robin pointer chooses the victim. Two control inputs clear either every slot, or only the non-global slots of one identifier.

The lookup and fill ports follow valid/ready rules: a request is taken on a clock edge where both valid and ready are high. Both ready outputs drop only in a cycle where a flush is requested. The result port has no back-pressure: `res_valid` pulses for exactly one cycle and must be captured then.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses, and `res_valid` is low.
- R2: A lookup accepted at edge N produces `res_valid` high for the cycle after edge N. `res_hit` reports a match. `res_pfn` and `res_dirty` carry the stored values on a hit and are both 0 on a miss. With no accepted lookup, `res_valid` is low.
- R3: A valid slot that is not global matches only when both its page number and its identifier equal the lookup's.
- R4: A valid global slot matches on its page number alone, whatever the lookup's identifier.
- R5: A fill whose page number equals that of a valid slot which either carries the same identifier or is global overwrites that slot and does not add a second copy.
- R6: A fill that overwrites nothing goes to the lowest-numbered invalid slot when one exists.
- R7: When all slots are valid, a new fill replaces the slot at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at the last slot, only on such a replacement.
- R8: `flush_asid_en` invalidates every valid non-global slot tagged with `flush_asid`. Global slots and slots of other identifiers are kept.
- R9: `flush_all` invalidates every slot, global ones included. It takes precedence over `flush_asid_en`.
- R10: In any cycle where `flush_all` or `flush_asid_en` is high, `lk_ready` and `fill_ready` are both low. Otherwise both are high.
- R11: A lookup and a fill accepted at the same edge: the lookup sees the slot contents from before that fill.
- R12: When several slots match one lookup, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| res_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| res_hit | output | 1 | Translation found |
| res_pfn | output | PFN_W | Frame number on a hit, 0 on a miss |
| res_dirty | output | 1 | Dirty flag of the hit slot, 0 on a miss |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill request can be taken |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_global | input | 1 | Install as global |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_dirty | input | 1 | Dirty flag to install |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate non-global slots of one identifier |
| flush_asid | input | ASID_W | Identifier for `flush_asid_en` |

## Verification
The bench builds the block with four slots, 6-bit page numbers, 2-bit identifiers and 5-bit frame numbers. With only four slots, a handful of fills forces round-robin replacement, and the pointer wraps within one directed sequence. With only four identifiers, random traffic keeps hitting per-identifier flushes, global slots shadowing private ones, and multi-match priority. The narrow page field makes overwrites of an existing page frequent, so the duplicate check is exercised often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned IDX_W = tlb_pkg::idx_width(N)
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0]        glob,
  input  logic [N*VPN_W-1:0]  vpn_flat,
  input  logic [N*ASID_W-1:0] asid_flat,
  input  logic [VPN_W-1:0]    key_vpn,
  input  logic [ASID_W-1:0]   key_asid,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);
  logic [N-1:0] hv;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hv[i] = valid[i]
                && (vpn_flat[i*VPN_W +: VPN_W] == key_vpn)
                && (glob[i] || (asid_flat[i*ASID_W +: ASID_W] == key_asid));
  end

  assign any = |hv;

  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hv[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = tlb_pkg::idx_width(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             fill_fire,
  input  logic             dup_any,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i]) free_idx = IDX_W'(i);
  end
  assign free_any = ~&valid;
  assign victim   = free_any ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (fill_fire && !dup_any && !free_any)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PFN_W   = 16,
  localparam int unsigned IDX_W  = tlb_pkg::idx_width(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PFN_W-1:0]  res_pfn,
  output logic              res_dirty,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_dirty,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  logic [ENTRIES-1:0]        valid_q, glob_q, dirty_q;
  logic [VPN_W-1:0]          vpn_q  [ENTRIES];
  logic [ASID_W-1:0]         asid_q [ENTRIES];
  logic [PFN_W-1:0]          pfn_q  [ENTRIES];
  logic [ENTRIES*VPN_W-1:0]  vpn_flat;
  logic [ENTRIES*ASID_W-1:0] asid_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign vpn_flat[i*VPN_W +: VPN_W]    = vpn_q[i];
    assign asid_flat[i*ASID_W +: ASID_W] = asid_q[i];
  end

  logic flushing, lk_fire, fill_fire;
  assign flushing   = flush_all | flush_asid_en;
  assign lk_ready   = ~flushing;
  assign fill_ready = ~flushing;
  assign lk_fire    = lk_valid & lk_ready;
  assign fill_fire  = fill_valid & fill_ready;

  logic             lk_any, dup_any;
  logic [IDX_W-1:0] lk_idx, dup_idx, vic_idx, wr_idx;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid(valid_q), .glob(glob_q), .vpn_flat(vpn_flat), .asid_flat(asid_flat),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .any(lk_any), .idx(lk_idx));

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_dup_match (
    .valid(valid_q), .glob(glob_q), .vpn_flat(vpn_flat), .asid_flat(asid_flat),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .any(dup_any), .idx(dup_idx));

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .fill_fire(fill_fire),
    .dup_any(dup_any), .victim(vic_idx));

  assign wr_idx = dup_any ? dup_idx : vic_idx;

  // slot state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      glob_q  <= '0;
      dirty_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
      end
    end else if (flush_all) begin
      valid_q <= '0;
    end else if (flush_asid_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!glob_q[i] && asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
    end else if (fill_fire) begin
      valid_q[wr_idx] <= 1'b1;
      glob_q[wr_idx]  <= fill_global;
      dirty_q[wr_idx] <= fill_dirty;
      vpn_q[wr_idx]   <= fill_vpn;
      asid_q[wr_idx]  <= fill_asid;
      pfn_q[wr_idx]   <= fill_pfn;
    end
  end

  // registered lookup result, taken from pre-update contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      res_dirty <= 1'b0;
    end else begin
      res_valid <= lk_fire;
      res_hit   <= lk_fire & lk_any;
      res_pfn   <= (lk_fire && lk_any) ? pfn_q[lk_idx] : '0;
      res_dirty <= lk_fire & lk_any & dirty_q[lk_idx];
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PFN_W   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_valid,
  input logic                      lk_ready,
  input logic                      fill_ready,
  input logic                      flush_all,
  input logic                      flush_asid_en,
  input logic [ASID_W-1:0]         flush_asid,
  input logic                      res_valid,
  input logic                      res_hit,
  input logic [PFN_W-1:0]          res_pfn,
  input logic                      res_dirty,
  input logic [ENTRIES-1:0]        valid_q,
  input logic [ENTRIES-1:0]        glob_q,
  input logic [ENTRIES*ASID_W-1:0] asid_flat
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !res_valid);
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_pfn == '0 && !res_dirty));
  a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> (!lk_ready && !fill_ready));
  a_r9_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    a_r8_tagged_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_asid_en && !flush_all && valid_q[i] && !glob_q[i]
       && asid_flat[i*ASID_W +: ASID_W] == flush_asid) |=> !valid_q[i]);
    a_r8_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_asid_en && !flush_all && valid_q[i] && glob_q[i]) |=> valid_q[i]);
  end
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .fill_ready(fill_ready), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
  .flush_asid(flush_asid), .res_valid(res_valid), .res_hit(res_hit),
  .res_pfn(res_pfn), .res_dirty(res_dirty), .valid_q(valid_q), .glob_q(glob_q),
  .asid_flat(asid_flat));

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  localparam int N = 4, VW = 6, AW = 2, PW = 5;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          lk_valid = 0, fill_valid = 0, fill_global = 0, fill_dirty = 0;
  logic          flush_all = 0, flush_asid_en = 0;
  logic [VW-1:0] lk_vpn = 0, fill_vpn = 0;
  logic [AW-1:0] lk_asid = 0, fill_asid = 0, flush_asid = 0;
  logic [PW-1:0] fill_pfn = 0, res_pfn;
  logic          lk_ready, fill_ready, res_valid, res_hit, res_dirty;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  bit m_v[N], m_g[N], m_d[N];
  int m_vpn[N], m_asid[N], m_pfn[N];
  int m_rr = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find(int vpn, int asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) return i;
    return -1;
  endfunction

  task automatic step(bit lv, int lvpn, int lasid,
                      bit fv, int fvpn, int fasid, bit fg, int fpfn, bit fd,
                      bit fa, bit fe, int fid, string req);
    int hit_i, slot;
    bit e_valid, e_hit, e_dirty, flush;
    int e_pfn;
    lk_valid = lv; lk_vpn = VW'(lvpn); lk_asid = AW'(lasid);
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_asid = AW'(fasid);
    fill_global = fg; fill_pfn = PW'(fpfn); fill_dirty = fd;
    flush_all = fa; flush_asid_en = fe; flush_asid = AW'(fid);
    #1;
    flush = fa || fe;
    chk(lk_ready == !flush && fill_ready == !flush, "R10 ready",
        {lk_ready, fill_ready}, flush ? 0 : 3);
    e_valid = lv && !flush;
    hit_i = e_valid ? find(lvpn, lasid) : -1;
    e_hit = hit_i >= 0;
    e_pfn = e_hit ? m_pfn[hit_i] : 0;
    e_dirty = e_hit ? m_d[hit_i] : 0;
    if (fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fe) begin
      for (int i = 0; i < N; i++) if (!m_g[i] && m_asid[i] == fid) m_v[i] = 0;
    end else if (fv) begin
      slot = find(fvpn, fasid);
      if (slot < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot] = 1; m_g[slot] = fg; m_d[slot] = fd;
      m_vpn[slot] = fvpn; m_asid[slot] = fasid; m_pfn[slot] = fpfn;
    end
    @(posedge clk); @(negedge clk);
    chk(res_valid == e_valid, {req, " valid"}, res_valid, e_valid);
    chk(res_hit == e_hit, {req, " hit"}, res_hit, e_hit);
    chk(res_pfn == PW'(e_pfn), {req, " pfn"}, res_pfn, e_pfn);
    chk(res_dirty == e_dirty, {req, " dirty"}, res_dirty, e_dirty);
  endtask

  task automatic look(int vpn, int asid, string req);
    step(1, vpn, asid, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic fill(int vpn, int asid, bit g, int pfn, bit d, string req);
    step(0, 0, 0, 1, vpn, asid, g, pfn, d, 0, 0, 0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R1 reset res_valid", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    look(1, 1, "R1 empty");
    fill(1, 1, 0, 10, 1, "R6 first");
    look(1, 1, "R2 hit");
    look(1, 2, "R3 asid miss");
    fill(2, 0, 1, 11, 0, "R6 second");
    look(2, 3, "R4 global");
    fill(1, 1, 0, 12, 0, "R5 overwrite");
    look(1, 1, "R5 new value");
    fill(3, 1, 0, 13, 1, "R6 third");
    fill(4, 2, 0, 14, 0, "R6 fourth");
    fill(5, 1, 0, 15, 0, "R7 evict0");
    look(1, 1, "R7 slot0 gone");
    fill(6, 3, 0, 16, 1, "R7 evict1");
    look(2, 0, "R7 slot1 gone");
    fill(7, 0, 1, 17, 0, "R7 evict2");
    fill(8, 0, 0, 18, 0, "R7 evict3");
    fill(9, 0, 0, 19, 0, "R7 wrap");
    look(9, 0, "R7 wrap hit");
    step(1, 7, 2, 1, 10, 1, 0, 1, 0, 0, 1, 0, "R10 flush asid");
    look(8, 0, "R8 dropped");
    look(7, 3, "R8 global kept");
    look(6, 3, "R8 other kept");
    fill(20, 1, 0, 20, 1, "R6 reuse free");
    step(1, 21, 2, 1, 21, 2, 0, 21, 0, 0, 0, 0, "R11 same edge");
    look(21, 2, "R11 after");
    fill(22, 1, 0, 2, 0, "R12 private");
    fill(22, 2, 1, 3, 1, "R12 global");
    look(22, 1, "R12 lowest");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, "R9 flush all");
    look(7, 3, "R9 global gone");
    look(22, 2, "R9 empty");
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 19);
      step($urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 3),
           r < 12, $urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 3) == 0,
           $urandom_range(0, 31), $urandom_range(0, 1),
           r == 19, r == 17 || r == 18, $urandom_range(0, 3), "R2 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule